// File: doc/BRIEF.md
# Channel Enable and Status Command Register Bank

This block is the control register bank of a multi-channel DMA controller. It holds four per-channel bit vectors: the request enable and the error-interrupt enable, which it drives to the channel engines, and the interrupt and error status, which it collects from those engines. Software never does a read-modify-write of a wide vector. It writes one byte, the number of a channel, to a dedicated command register. Each command register performs one fixed operation on that channel's bit. Because a single byte write touches only the named bit, concurrent agents cannot corrupt each other's channels.

A parameter selects a 32-channel or a 64-channel layout. The two layouts place the eight command bytes at different offsets within the same 0x18..0x1F window. The wide layout also adds high-half words for each vector. To bring a channel up, software sets its error-interrupt enable and then its request enable. To take it down, it clears the request enable first and the error-interrupt enable second. Two commands produce single-cycle pulses rather than stored bits: a software start and a done-flag clear, both sent to the addressed channel.

Top module: `chan_ctl_bank`

## Requirements
- R1: After reset, every request enable, error-interrupt enable, interrupt status and error status bit is 0, and no start or done-clear pulse is driven.
- R2: A write of channel index c to the set-request byte (0x1B in the 32-channel layout, 0x18 in the 64-channel layout) sets `req_en_o[c]`. A write to the clear-request byte (0x1A / 0x19) clears it. The change is visible on the output one cycle after the write.
- R3: A write of c to the set-error-enable byte (0x19 / 0x1A) sets `err_int_en_o[c]`. A write to the clear-error-enable byte (0x18 / 0x1B) clears it.
- R4: In a command byte, bits [log2(NUM_CH)-1:0] are the channel index. Bit 6 set means all channels. Bit 7, and any bit between the index field and bit 6, is ignored.
- R5: A pulse on `int_set_i[c]` sets interrupt status bit c, and the bit holds until it is cleared. A write of c to the clear-interrupt byte (0x1F / 0x1C) clears it.
- R6: A pulse on `err_set_i[c]` sets error status bit c, and the bit holds until it is cleared. A write of c to the clear-error byte (0x1E / 0x1D) clears it.
- R7: When a clear-interrupt or clear-error write names a channel in the same cycle as that channel's set pulse, the clear wins. Set pulses on channels the write does not name still take effect.
- R8: A write of c to the set-start byte (0x1D / 0x1E) drives `start_o[c]` high for exactly one cycle, starting one cycle after the write. A write to the clear-done byte (0x1C / 0x1F) does the same on `done_clr_o[c]`.
- R9: A read strobe returns `rd_valid_o` and `rdata_o` one cycle later. The word offsets are: request enable low 0x0C and high 0x08; error-interrupt enable low 0x14 and high 0x10; interrupt status low 0x24 and high 0x20; error status low 0x2C and high 0x28. Bit k of a low word is channel k, and bit k of a high word is channel 32+k. High words read zero in the 32-channel layout.
- R10: Reads of the command bytes 0x18..0x1F, and of any unmapped offset, return zero.
- R11: A command changes only the bit of the channel it names. All other bits of every vector keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Command byte write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset for the write or read |
| wdata_i | input | 8 | Command byte (channel index and all-channels bit) |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rdata_o | output | 32 | Read data |
| int_set_i | input | NUM_CH | Per-channel interrupt set pulses from the engines |
| err_set_i | input | NUM_CH | Per-channel error set pulses from the engines |
| req_en_o | output | NUM_CH | Per-channel request enable |
| err_int_en_o | output | NUM_CH | Per-channel error-interrupt enable |
| start_o | output | NUM_CH | One-cycle software start pulse per channel |
| done_clr_o | output | NUM_CH | One-cycle done-clear pulse per channel |

## Verification
The bench builds instance u0 with NUM_CH=64 and a second instance with NUM_CH=32. Both layouts' command offsets and index widths are therefore driven.

The 64-channel instance reaches the high-half words and channel indices above 31. These show whether the index field and the all-channels bit decode correctly at full width. The 32-channel instance shows that bit 5 of a command byte is ignored there, and that the same offsets decode to different operations.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  typedef enum logic [3:0] {
    CMD_NONE, CMD_SET_REQ, CMD_CLR_REQ, CMD_SET_EEI, CMD_CLR_EEI,
    CMD_CLR_INT, CMD_CLR_ERR, CMD_SET_START, CMD_CLR_DONE
  } cmd_e;

  localparam int unsigned ALL_BIT = 6;

  localparam logic [7:0] OFS_REQ_HI = 8'h08;
  localparam logic [7:0] OFS_REQ_LO = 8'h0C;
  localparam logic [7:0] OFS_EEI_HI = 8'h10;
  localparam logic [7:0] OFS_EEI_LO = 8'h14;
  localparam logic [7:0] OFS_INT_HI = 8'h20;
  localparam logic [7:0] OFS_INT_LO = 8'h24;
  localparam logic [7:0] OFS_ERR_HI = 8'h28;
  localparam logic [7:0] OFS_ERR_LO = 8'h2C;

  function automatic cmd_e map_cmd(input logic [7:0] a, input logic wide);
    cmd_e c;
    c = CMD_NONE;
    if (wide) begin
      case (a)
        8'h18: c = CMD_SET_REQ;
        8'h19: c = CMD_CLR_REQ;
        8'h1A: c = CMD_SET_EEI;
        8'h1B: c = CMD_CLR_EEI;
        8'h1C: c = CMD_CLR_INT;
        8'h1D: c = CMD_CLR_ERR;
        8'h1E: c = CMD_SET_START;
        8'h1F: c = CMD_CLR_DONE;
        default: c = CMD_NONE;
      endcase
    end else begin
      case (a)
        8'h18: c = CMD_CLR_EEI;
        8'h19: c = CMD_SET_EEI;
        8'h1A: c = CMD_CLR_REQ;
        8'h1B: c = CMD_SET_REQ;
        8'h1C: c = CMD_CLR_DONE;
        8'h1D: c = CMD_SET_START;
        8'h1E: c = CMD_CLR_ERR;
        8'h1F: c = CMD_CLR_INT;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/chan_ctl_decode.sv
module chan_ctl_decode
  import chan_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [NUM_CH-1:0] set_req_o,
  output logic [NUM_CH-1:0] clr_req_o,
  output logic [NUM_CH-1:0] set_eei_o,
  output logic [NUM_CH-1:0] clr_eei_o,
  output logic [NUM_CH-1:0] clr_int_o,
  output logic [NUM_CH-1:0] clr_err_o,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);
  localparam logic        WIDE = (NUM_CH > 32);

  cmd_e              cmd;
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] one;

  assign one = NUM_CH'(1);
  assign cmd = wr_en_i ? map_cmd(addr_i, WIDE) : CMD_NONE;
  // bit 6 selects every channel; bits above the index field otherwise ignored
  assign mask = wdata_i[ALL_BIT] ? '1 : (one << wdata_i[CH_W-1:0]);

  always_comb begin
    set_req_o = '0;
    clr_req_o = '0;
    set_eei_o = '0;
    clr_eei_o = '0;
    clr_int_o = '0;
    clr_err_o = '0;
    start_o   = '0;
    done_o    = '0;
    case (cmd)
      CMD_SET_REQ:   set_req_o = mask;
      CMD_CLR_REQ:   clr_req_o = mask;
      CMD_SET_EEI:   set_eei_o = mask;
      CMD_CLR_EEI:   clr_eei_o = mask;
      CMD_CLR_INT:   clr_int_o = mask;
      CMD_CLR_ERR:   clr_err_o = mask;
      CMD_SET_START: start_o   = mask;
      CMD_CLR_DONE:  done_o    = mask;
      default: ;
    endcase
  end
endmodule

// File: rtl/chan_ctl_bits.sv
module chan_ctl_bits #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // clear dominates set on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/chan_ctl_bank.sv
module chan_ctl_bank
  import chan_ctl_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic              rd_valid_o,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] int_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  output logic [NUM_CH-1:0] req_en_o,
  output logic [NUM_CH-1:0] err_int_en_o,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_clr_o
);
  localparam int unsigned NVEC = 4;
  localparam int unsigned V_REQ = 0, V_EEI = 1, V_INT = 2, V_ERR = 3;

  logic [NUM_CH-1:0] set_req, clr_req, set_eei, clr_eei, clr_int, clr_err;
  logic [NUM_CH-1:0] start_d, done_d;
  logic [NUM_CH-1:0] vset [NVEC];
  logic [NUM_CH-1:0] vclr [NVEC];
  logic [NUM_CH-1:0] vq   [NVEC];
  logic [NUM_CH-1:0] int_stat, err_stat;

  chan_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .set_req_o(set_req),
    .clr_req_o(clr_req),
    .set_eei_o(set_eei),
    .clr_eei_o(clr_eei),
    .clr_int_o(clr_int),
    .clr_err_o(clr_err),
    .start_o  (start_d),
    .done_o   (done_d)
  );

  assign vset[V_REQ] = set_req;
  assign vclr[V_REQ] = clr_req;
  assign vset[V_EEI] = set_eei;
  assign vclr[V_EEI] = clr_eei;
  assign vset[V_INT] = int_set_i;
  assign vclr[V_INT] = clr_int;
  assign vset[V_ERR] = err_set_i;
  assign vclr[V_ERR] = clr_err;

  for (genvar k = 0; k < NVEC; k++) begin : g_vec
    chan_ctl_bits #(.N(NUM_CH)) u_bits (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (vset[k]),
      .clr_i (vclr[k]),
      .q_o   (vq[k])
    );
  end

  assign req_en_o     = vq[V_REQ];
  assign err_int_en_o = vq[V_EEI];
  assign int_stat     = vq[V_INT];
  assign err_stat     = vq[V_ERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o    <= '0;
      done_clr_o <= '0;
    end else begin
      start_o    <= start_d;
      done_clr_o <= done_d;
    end
  end

  // zero-extended to 64 so the high words read zero in the narrow layout
  logic [63:0] req_w, eei_w, int_w, err_w;
  logic [31:0] rd_word;
  assign req_w = 64'(req_en_o);
  assign eei_w = 64'(err_int_en_o);
  assign int_w = 64'(int_stat);
  assign err_w = 64'(err_stat);

  always_comb begin
    case (addr_i)
      OFS_REQ_HI: rd_word = req_w[63:32];
      OFS_REQ_LO: rd_word = req_w[31:0];
      OFS_EEI_HI: rd_word = eei_w[63:32];
      OFS_EEI_LO: rd_word = eei_w[31:0];
      OFS_INT_HI: rd_word = int_w[63:32];
      OFS_INT_LO: rd_word = int_w[31:0];
      OFS_ERR_HI: rd_word = err_w[63:32];
      OFS_ERR_LO: rd_word = err_w[31:0];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rdata_o    <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/chan_ctl_bank_chk.sv
module chan_ctl_bank_chk #(
  parameter int unsigned NUM_CH = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        addr_i,
  input logic              rd_valid_o,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] int_set_i,
  input logic [NUM_CH-1:0] err_set_i,
  input logic [NUM_CH-1:0] int_stat,
  input logic [NUM_CH-1:0] err_stat,
  input logic [NUM_CH-1:0] req_en_o,
  input logic [NUM_CH-1:0] err_int_en_o,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] done_clr_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(req_en_o));
  assert_eei_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(err_int_en_o));
  assert_int_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((int_stat & $past(int_set_i)) == $past(int_set_i)));
  assert_err_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((err_stat & $past(err_set_i)) == $past(err_set_i)));
  assert_int_no_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((int_stat & $past(int_stat)) == $past(int_stat)));
  assert_pulse_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|start_o) || (|done_clr_o)) |-> $past(wr_en_i));
  assert_rd_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_cmd_read_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i >= 8'h18 && addr_i <= 8'h1F) |=> (rdata_o == 32'h0));
endmodule

bind chan_ctl_bank chan_ctl_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .rd_valid_o  (rd_valid_o),
  .rdata_o     (rdata_o),
  .int_set_i   (int_set_i),
  .err_set_i   (err_set_i),
  .int_stat    (int_stat),
  .err_stat    (err_stat),
  .req_en_o    (req_en_o),
  .err_int_en_o(err_int_en_o),
  .start_o     (start_o),
  .done_clr_o  (done_clr_o)
);

// File: tb/sim_chan_ctl_bank.sv
`timescale 1ns/1ps
module sim_chan_ctl_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // 64-channel instance
  logic        we0 = 0, re0 = 0;
  logic [7:0]  a0 = 0, d0 = 0;
  logic [63:0] is0 = 0, es0 = 0;
  logic        rv0;
  logic [31:0] rd0;
  logic [63:0] req0, eei0, st0, dn0;

  chan_ctl_bank #(.NUM_CH(64)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we0), .rd_en_i(re0), .addr_i(a0),
    .wdata_i(d0), .rd_valid_o(rv0), .rdata_o(rd0), .int_set_i(is0),
    .err_set_i(es0), .req_en_o(req0), .err_int_en_o(eei0), .start_o(st0),
    .done_clr_o(dn0)
  );

  // 32-channel instance
  logic        we1 = 0, re1 = 0;
  logic [7:0]  a1 = 0, d1 = 0;
  logic [31:0] is1 = 0, es1 = 0;
  logic        rv1;
  logic [31:0] rd1;
  logic [31:0] req1, eei1, st1, dn1;

  chan_ctl_bank #(.NUM_CH(32)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we1), .rd_en_i(re1), .addr_i(a1),
    .wdata_i(d1), .rd_valid_o(rv1), .rdata_o(rd1), .int_set_i(is1),
    .err_set_i(es1), .req_en_o(req1), .err_int_en_o(eei1), .start_o(st1),
    .done_clr_o(dn1)
  );

  // reference model for u0
  logic [63:0] m_req = 0, m_eei = 0, m_int = 0, m_err = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // monitor: compares read results as they appear
  always @(negedge clk) begin
    if (rst_n && rv0) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9: unexpected read valid, actual %h expected none", rd0);
      end else begin
        chk(tag_q.pop_front(), {32'h0, rd0}, {32'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr0(input logic [7:0] a, input logic [7:0] d,
                     input logic [63:0] is = 0, input logic [63:0] es = 0);
    @(negedge clk);
    we0 = 1; a0 = a; d0 = d; is0 = is; es0 = es;
    @(negedge clk);
    we0 = 0; is0 = 0; es0 = 0;
  endtask

  task automatic pulse0(input logic [63:0] is, input logic [63:0] es);
    @(negedge clk);
    is0 = is; es0 = es;
    @(negedge clk);
    is0 = 0; es0 = 0;
  endtask

  task automatic rd_exp0(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(r);
    re0 = 1; a0 = a;
    @(negedge clk);
    re0 = 0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d,
                     input logic [31:0] is = 0, input logic [31:0] es = 0);
    @(negedge clk);
    we1 = 1; a1 = a; d1 = d; is1 = is; es1 = es;
    @(negedge clk);
    we1 = 0; is1 = 0; es1 = 0;
  endtask

  task automatic rd_exp1(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk);
    re1 = 1; a1 = a;
    @(negedge clk);
    re1 = 0;
    chk(r, {32'h0, rd1}, {32'h0, exp});
  endtask

  initial begin
    #(4 * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", req0, 0);
    chk("R1 eei", eei0, 0);
    chk("R1 pulses", st0 | dn0, 0);
    rd_exp0(8'h24, 32'h0, "R1 int lo");
    rd_exp0(8'h2C, 32'h0, "R1 err lo");

    // R3 then R2: enable order on ch 3 and ch 40 (64-ch map)
    wr0(8'h1A, 8'd3); m_eei[3] = 1;
    chk("R3 set eei", eei0, m_eei);
    wr0(8'h18, 8'd3); m_req[3] = 1;
    chk("R2 set req", req0, m_req);
    wr0(8'h18, 8'd40); m_req[40] = 1;
    chk("R2 set req hi", req0, m_req);
    chk("R11 eei untouched", eei0, m_eei);
    rd_exp0(8'h08, m_req[63:32], "R9 req hi");
    rd_exp0(8'h0C, m_req[31:0], "R9 req lo");
    rd_exp0(8'h14, m_eei[31:0], "R9 eei lo");

    // R4: bit 7 ignored
    wr0(8'h19, 8'h80 | 8'd40); m_req[40] = 0;
    chk("R4 bit7 ignored clr req", req0, m_req);
    // R4: all channels
    wr0(8'h18, 8'h40); m_req = '1;
    chk("R4 all set req", req0, m_req);
    wr0(8'h19, 8'h40 | 8'd5); m_req = '0;
    chk("R4 all clr req", req0, m_req);
    wr0(8'h1B, 8'd3); m_eei[3] = 0;
    chk("R3 clr eei", eei0, m_eei);

    // R5 interrupt capture and clear
    pulse0(64'h1 << 7 | 64'h1 << 50, 0); m_int[7] = 1; m_int[50] = 1;
    rd_exp0(8'h24, m_int[31:0], "R5 int lo");
    rd_exp0(8'h20, m_int[63:32], "R5 int hi");
    wr0(8'h1C, 8'd7); m_int[7] = 0;
    rd_exp0(8'h24, m_int[31:0], "R5 clr int");

    // R7: clear named channel wins; other set proceeds
    wr0(8'h1C, 8'd50, 64'h1 << 50 | 64'h1 << 12, 0); m_int[50] = 0; m_int[12] = 1;
    rd_exp0(8'h20, m_int[63:32], "R7 clr wins ch50");
    rd_exp0(8'h24, m_int[31:0], "R7 other set ch12");

    // R6 error capture and clear
    pulse0(0, 64'h1 << 33); m_err[33] = 1;
    rd_exp0(8'h28, m_err[63:32], "R6 err hi");
    wr0(8'h1D, 8'h40, 0, 64'h1 << 2); m_err = 0;
    rd_exp0(8'h28, m_err[63:32], "R7 all clr err hi");
    rd_exp0(8'h2C, m_err[31:0], "R7 all clr beats set ch2");

    // R8 start / done pulses
    wr0(8'h1E, 8'd9);
    chk("R8 start pulse", st0, 64'h1 << 9);
    @(negedge clk);
    chk("R8 start one cycle", st0, 0);
    wr0(8'h1F, 8'd63);
    chk("R8 done pulse", dn0, 64'h1 << 63);
    chk("R11 no start on done", st0, 0);
    @(negedge clk);
    chk("R8 done one cycle", dn0, 0);

    // R10 command bytes and unmapped read zero
    rd_exp0(8'h18, 32'h0, "R10 cmd byte");
    rd_exp0(8'h30, 32'h0, "R10 unmapped");

    // 32-channel layout
    wr1(8'h1B, 8'd5);
    chk("R2 narrow set req", {32'h0, req1}, 64'h1 << 5);
    wr1(8'h19, 8'h20 | 8'd4);
    chk("R4 narrow bit5 ignored", {32'h0, eei1}, 64'h1 << 4);
    rd_exp1(8'h0C, 32'h1 << 5, "R9 narrow req lo");
    rd_exp1(8'h08, 32'h0, "R9 narrow hi zero");
    wr1(8'h1A, 8'd5);
    chk("R2 narrow clr req", {32'h0, req1}, 0);
    wr1(8'h18, 8'd4);
    chk("R3 narrow clr eei", {32'h0, eei1}, 0);
    wr1(8'h1D, 8'd31);
    chk("R8 narrow start", {32'h0, st1}, 64'h1 << 31);
    wr1(8'h1C, 8'd0);
    chk("R8 narrow done", {32'h0, dn1}, 64'h1);
    wr1(8'h1F, 8'd6, 32'h3 << 6, 32'h1 << 1);
    rd_exp1(8'h24, 32'h1 << 7, "R7 narrow clr int");
    wr1(8'h1E, 8'd1);
    rd_exp1(8'h2C, 32'h0, "R6 narrow clr err");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R9: pending reads actual %0d expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule